// File: doc/BRIEF.md
# Message-Signalled Interrupt Redirection Translator

This block sits between a device-side interrupt write and a small system bus that links eight processor-local interrupt controllers. It receives one write, made of a 32-bit address and a 32-bit data word. It splits that write into a destination ID, a destination-mode flag, a redirection-hint flag and an interrupt vector. It then produces one interrupt message for the bus.

When the hint flag is clear, the destination and the mode pass through untouched. When the hint flag is set and the mode is logical, the block narrows a mask that may name several processors down to a single processor: the one whose current interrupt priority is lowest. Each processor supplies a 4-bit priority value on a flat input vector. A physical destination already names one processor, so it is never changed.

The output is held in a single register stage with a valid/ready handshake. The input is stalled while that stage is occupied, so only one message is handled at a time.

Top module: `msi_redirect_xlate`

## Requirements
- R1: With address bit 3 (hint) at 0, the message carries destination = address bits 19:12 and logical flag = address bit 2, both exactly as received. The vector always equals data bits 7:0.
- R2: With the hint at 1 and address bit 2 at 0 (physical mode), the destination and the mode are forwarded unchanged.
- R3: With the hint at 1, address bit 2 at 1 and a non-zero destination, the emitted destination has exactly one bit set, and that bit is set in the incoming destination.
- R4: The bit kept under R3 belongs to the slot with the numerically lowest priority among the named slots. Slot i takes its priority from cpu_prio bits 4i+3:4i, and the priority values are those present in the cycle the message is accepted.
- R5: When several named slots share the lowest priority, the lowest-numbered of them is chosen.
- R6: With the hint at 1, logical mode and a destination of zero, the message is emitted with an all-zero destination. err_no_target is high for exactly one cycle, the first cycle in which that message is valid.
- R7: A message accepted on a clock edge (in_valid and in_ready both high) is presented with out_valid high from that same edge onward, which is one cycle of registered latency.
- R8: in_ready is low whenever out_valid is high. While out_valid is high and out_ready is low, out_dest, out_logical and out_vector stay stable and out_valid stays high.
- R9: After a synchronous reset with rst_n low, out_valid and err_no_target are 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An interrupt write is offered |
| in_ready | output | 1 | The block can take a write this cycle |
| in_addr | input | 32 | Address of the interrupt write |
| in_data | input | 32 | Data of the interrupt write |
| cpu_prio | input | 32 | Current priority per processor slot, 4 bits each, slot 0 in the low bits |
| out_valid | output | 1 | An interrupt message is presented |
| out_ready | input | 1 | The system bus takes the message |
| out_dest | output | 8 | Destination field of the message |
| out_logical | output | 1 | 1 for logical destination mode, 0 for physical |
| out_vector | output | 8 | Interrupt vector |
| err_no_target | output | 1 | One-cycle flag: redirection was asked for with an empty mask |

## Verification
The held message lives in one register, so a faulty hold shows on the next clock at the latest. A faulty capture shows as a wrong out_dest, out_logical or out_vector in the first cycle out_valid is high. A stuck valid bit shows as in_ready staying low, or as a message that is presented twice. A fault in the selection logic shows as a destination carrying more than one bit, or as a bit that belongs to a slot with a higher priority. Ties among equal priorities are exercised on purpose, because a choice that is wrong only on ties looks correct for distinct priorities.

// File: rtl/msi_xlate_pkg.sv
// Shared widths and message types for the interrupt redirection translator.
// Assumes an 8-slot system, so the destination mask width equals the slot count.
package msi_xlate_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int DEST_W = 8;
    localparam int VEC_W  = 8;

    // Fields taken from one incoming interrupt write
    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              logical;
        logic              hint;
        logic [VEC_W-1:0]  vector;
    } msi_fields_t;

    // Message as driven onto the system bus
    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              logical;
        logic [VEC_W-1:0]  vector;
    } irq_msg_t;
endpackage

// File: rtl/msi_field_decode.sv
// Splits an interrupt write into destination, mode flag, hint flag and vector.
// Assumes the field positions are given by the parameters; other bits are ignored.
module msi_field_decode
    import msi_xlate_pkg::*;
#(
    parameter int DEST_LSB = 12,
    parameter int DM_BIT   = 2,
    parameter int RH_BIT   = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output msi_fields_t       fields
);
    logic unused_bits;

    // Field extraction from the write address and the write data
    always_comb begin
        fields.dest    = addr[DEST_LSB +: DEST_W];
        fields.logical = addr[DM_BIT];
        fields.hint    = addr[RH_BIT];
        fields.vector  = data[VEC_W-1:0];
    end

    assign unused_bits = ^{addr, data};
endmodule

// File: rtl/lowprio_pick.sv
// Chooses one requester out of a mask: the lowest priority value wins and
// ties go to the lowest index. Assumes that smaller numbers mean lower priority.
module lowprio_pick #(
    parameter int N  = 8,
    parameter int PW = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    req,
    input  logic [N*PW-1:0] prio_flat,
    output logic [N-1:0]    grant,
    output logic            none
);
    logic [PW-1:0]    prio [N];
    logic [PW-1:0]    best_p;
    logic [IDX_W-1:0] best_i;
    logic             found;

    // Unpack the flat priority vector, one slice per slot
    for (genvar g = 0; g < N; g++) begin : g_unpack
        assign prio[g] = prio_flat[g*PW +: PW];
    end

    // Scan upward; a strict compare keeps the earliest of equal minima
    always_comb begin
        found  = 1'b0;
        best_p = '1;
        best_i = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!found || prio[i] < best_p)) begin
                found  = 1'b1;
                best_p = prio[i];
                best_i = IDX_W'(i);
            end
        end
    end

    // One-hot grant from the winning index
    always_comb begin
        grant         = '0;
        grant[best_i] = found;
        none          = !found;
    end
endmodule

// File: rtl/msg_stage.sv
// Single output register holding one message until the consumer accepts it.
// Assumes load is only asserted while the stage is empty.
module msg_stage
    import msi_xlate_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  irq_msg_t next_msg,
    input  logic     next_err,
    input  logic     drain,
    output logic     valid,
    output irq_msg_t msg,
    output logic     err
);
    // Occupancy flag: set on load, cleared when the consumer takes the message
    always_ff @(posedge clk) begin
        if (!rst_n)             valid <= 1'b0;
        else if (load)          valid <= 1'b1;
        else if (valid && drain) valid <= 1'b0;
    end

    // Message payload, captured only on load
    always_ff @(posedge clk) begin
        if (!rst_n)    msg <= '0;
        else if (load) msg <= next_msg;
    end

    // Error flag lasts only the first cycle of the loaded message
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= load && next_err;
    end
endmodule

// File: rtl/msi_redirect_xlate.sv
// Turns an interrupt write into a system-bus interrupt message. A set hint in
// logical mode narrows the destination to the lowest-priority named slot.
// Assumes that cpu_prio is valid in the cycle a write is accepted.
module msi_redirect_xlate
    import msi_xlate_pkg::*;
#(
    parameter int PRIO_W   = 4,
    parameter int DEST_LSB = 12,
    parameter int DM_BIT   = 2,
    parameter int RH_BIT   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [ADDR_W-1:0]        in_addr,
    input  logic [DATA_W-1:0]        in_data,
    input  logic [DEST_W*PRIO_W-1:0] cpu_prio,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [DEST_W-1:0]        out_dest,
    output logic                     out_logical,
    output logic [VEC_W-1:0]         out_vector,
    output logic                     err_no_target
);
    msi_fields_t       f;
    logic [DEST_W-1:0] grant;
    logic              none;
    logic              redirect;
    logic              load;
    irq_msg_t          next_msg;
    irq_msg_t          held;

    msi_field_decode #(.DEST_LSB(DEST_LSB), .DM_BIT(DM_BIT), .RH_BIT(RH_BIT)) u_dec (
        .addr   (in_addr),
        .data   (in_data),
        .fields (f)
    );

    lowprio_pick #(.N(DEST_W), .PW(PRIO_W)) u_pick (
        .req       (f.dest),
        .prio_flat (cpu_prio),
        .grant     (grant),
        .none      (none)
    );

    // Accept only into an empty stage; build the outgoing message
    always_comb begin
        in_ready         = !out_valid;
        load             = in_valid && in_ready;
        redirect         = f.hint && f.logical;
        next_msg.dest    = redirect ? grant : f.dest;
        next_msg.logical = f.logical;
        next_msg.vector  = f.vector;
    end

    msg_stage u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .next_msg (next_msg),
        .next_err (redirect && none),
        .drain    (out_ready),
        .valid    (out_valid),
        .msg      (held),
        .err      (err_no_target)
    );

    // Drive the bus-side fields from the held message
    always_comb begin
        out_dest    = held.dest;
        out_logical = held.logical;
        out_vector  = held.vector;
    end
endmodule

// File: rtl/msi_xlate_checker.sv
// Temporal properties of the translator, observed at its ports.
// Assumes the default field positions of the top module.
module msi_xlate_checker #(
    parameter int DEST_LSB = 12,
    parameter int DM_BIT   = 2,
    parameter int RH_BIT   = 3
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic [31:0] in_addr,
    input logic [31:0] in_data,
    input logic        out_valid,
    input logic        out_ready,
    input logic [7:0]  out_dest,
    input logic        out_logical,
    input logic [7:0]  out_vector,
    input logic        err_no_target
);
    logic       acc;
    logic [7:0] a_dest;
    assign acc    = in_valid && in_ready;
    assign a_dest = in_addr[DEST_LSB +: 8];

    p_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !in_addr[RH_BIT] |=> out_dest == $past(a_dest) && out_logical == $past(in_addr[DM_BIT]));

    p_vector_r1: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> out_vector == $past(in_data[7:0]));

    p_phys_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc && in_addr[RH_BIT] && !in_addr[DM_BIT] |=> out_dest == $past(a_dest) && !out_logical);

    p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc && in_addr[RH_BIT] && in_addr[DM_BIT] && a_dest != 8'h00
        |=> $countones(out_dest) == 1 && (out_dest & ~$past(a_dest)) == 8'h00);

    p_err_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_no_target |=> !err_no_target);

    p_err_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_no_target |-> out_valid && out_dest == 8'h00);

    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> out_valid);

    p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_dest) && $stable(out_logical) && $stable(out_vector));
endmodule

bind msi_redirect_xlate msi_xlate_checker #(
    .DEST_LSB(DEST_LSB), .DM_BIT(DM_BIT), .RH_BIT(RH_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_dest(out_dest), .out_logical(out_logical),
    .out_vector(out_vector), .err_no_target(err_no_target)
);

// File: tb/tb_msi_redirect_xlate.sv
module tb_msi_redirect_xlate;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_addr = '0;
    logic [31:0] in_data = '0;
    logic [31:0] cpu_prio = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_dest;
    logic        out_logical;
    logic [7:0]  out_vector;
    logic        err_no_target;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;
    int rdy_mode = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_redirect_xlate dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_data(in_data), .cpu_prio(cpu_prio),
        .out_valid(out_valid), .out_ready(out_ready), .out_dest(out_dest),
        .out_logical(out_logical), .out_vector(out_vector),
        .err_no_target(err_no_target)
    );

    typedef struct {
        logic [7:0] dest;
        logic       logical;
        logic [7:0] vec;
        string      tag;
    } exp_t;

    exp_t q[$];
    bit   exp_err = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cycles, act, exp);
        end
    endtask

    // Reference model: expected message built from the requirements alone
    function automatic exp_t model(input logic [31:0] a, input logic [31:0] d, input logic [31:0] p);
        exp_t e;
        logic [7:0] m;
        int best, bestp, nbest;
        m = a[19:12];
        e.logical = a[2];
        e.vec = d[7:0];
        e.dest = m;
        if (!a[3]) e.tag = "R1";
        else if (!a[2]) e.tag = "R2";
        else if (m == 0) e.tag = "R6";
        else begin
            best = -1; bestp = 99;
            for (int i = 0; i < 8; i++)
                if (m[i] && int'(p[4*i +: 4]) < bestp) begin best = i; bestp = int'(p[4*i +: 4]); end
            nbest = 0;
            for (int i = 0; i < 8; i++)
                if (m[i] && int'(p[4*i +: 4]) == bestp) nbest++;
            e.dest = 8'h00;
            e.dest[best] = 1'b1;
            if (nbest > 1) e.tag = "R5";
            else if ($countones(m) > 1) e.tag = "R4";
            else e.tag = "R3";
        end
        return e;
    endfunction

    // Model update on every rising edge from the inputs present before it
    always @(posedge clk) begin
        bit acc, fire, nerr;
        exp_t e;
        cycles++;
        if (!rst_n) begin
            q.delete();
            exp_err = 1'b0;
        end else begin
            acc  = in_valid && (q.size() == 0);
            fire = (q.size() != 0) && out_ready;
            nerr = 1'b0;
            if (fire) void'(q.pop_front());
            if (acc) begin
                e = model(in_addr, in_data, cpu_prio);
                q.push_back(e);
                nerr = (e.tag == "R6");
            end
            exp_err = nerr;
        end
    end

    // Compare the ports against the model on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(in_ready == (q.size() == 0), "R8 in_ready", 32'(in_ready), 32'(q.size() == 0));
            check(out_valid == (q.size() != 0), "R7 out_valid", 32'(out_valid), 32'(q.size() != 0));
            check(err_no_target == exp_err, "R6 err_no_target", 32'(err_no_target), 32'(exp_err));
            if (q.size() != 0) begin
                check(out_dest == q[0].dest, {q[0].tag, " out_dest"}, 32'(out_dest), 32'(q[0].dest));
                check(out_logical == q[0].logical, "R1 out_logical", 32'(out_logical), 32'(q[0].logical));
                check(out_vector == q[0].vec, "R1 out_vector", 32'(out_vector), 32'(q[0].vec));
                if (q[0].tag == "R3" || q[0].tag == "R4" || q[0].tag == "R5")
                    check($countones(out_dest) == 1, "R3 one-hot", 32'(out_dest), 32'h1);
            end
        end
    end

    // Consumer side: always ready, or stalling on a pseudo-random pattern
    always @(negedge clk) begin
        if (rdy_mode == 0) out_ready <= 1'b1;
        else               out_ready <= ($urandom % 3) != 0;
    end

    task automatic send(input logic [7:0] dest, input bit rh, input bit dm,
                        input logic [31:0] data, input logic [31:0] prio);
        bit took;
        @(negedge clk);
        in_valid = 1'b1;
        in_addr  = 32'hFEE0_0000 | (32'(dest) << 12) | (32'(rh) << 3) | (32'(dm) << 2);
        in_data  = data;
        cpu_prio = prio;
        forever begin
            took = in_ready;
            @(negedge clk);
            if (took) break;
        end
        in_valid = 1'b0;
        cpu_prio = 32'hFFFF_FFFF;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired at cycle %0d: actual %0d expected %0d", cycles, 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        check(out_valid == 1'b0, "R9 out_valid", 32'(out_valid), 0);
        check(err_no_target == 1'b0, "R9 err_no_target", 32'(err_no_target), 0);
        check(in_ready == 1'b1, "R9 in_ready", 32'(in_ready), 1);
        // R1: no hint, multi-bit logical and physical pass through
        send(8'hA5, 0, 1, 32'h1234_5642, 32'h0123_4567);
        send(8'hA5, 0, 0, 32'h0000_00E1, 32'h7654_3210);
        // R2: hint with physical mode unchanged
        send(8'h37, 1, 0, 32'h0000_0033, 32'h0000_0000);
        // R3: single named slot
        send(8'h40, 1, 1, 32'h0000_0099, 32'h0000_0000);
        // R4: distinct priorities, slot 5 is lowest
        send(8'hE6, 1, 1, 32'h0000_0010, 32'h9F2F_5F7F);
        // R5: slots 2 and 6 tie at 1
        send(8'h44, 1, 1, 32'h0000_0011, 32'h3100_0100);
        send(8'hFF, 1, 1, 32'h0000_0012, 32'h0000_0000);
        // R6: redirection with empty mask
        send(8'h00, 1, 1, 32'h0000_0013, 32'h1111_1111);
        send(8'h00, 0, 1, 32'h0000_0014, 32'h1111_1111);
        // R8: back-pressure with a pseudo-random consumer
        rdy_mode = 1;
        for (int k = 0; k < 400; k++)
            send(8'($urandom), 1'($urandom), 1'($urandom), $urandom, $urandom & 32'h3333_3333);
        rdy_mode = 0;
        repeat (6) @(negedge clk);
        finish_run();
    end
endmodule